// File: doc/BRIEF.md
# Dual-Channel UART Register Controller

This block is the host-facing register file and control logic for a pair of serial channels that share one register block. A byte-wide bus reads and writes per-channel mode, status, command and holding registers, plus a block-wide interrupt status and mask register. It does not time serial bits. A receive stream per channel delivers characters and break events into a three-entry FIFO. A transmit strobe per channel carries characters that the host writes while the transmitter is enabled. The interrupt status and mask bits go out as plain vectors, and an external aggregator combines them into interrupt lines.

Each bus access decodes in the cycle it is presented. Read data is combinational while `bus_rd` is high. Side effects such as popping the FIFO or advancing the mode pointer take place at the clock edge that ends the access. When `bus_rd` and `bus_wr` are both high, the write is performed and the read is ignored. The receive stream uses valid/ready: a character is taken on a cycle with `rx_valid` and `rx_ready` both high, and the source must hold it otherwise. `rx_ready` is low while the receiver is disabled or the FIFO holds three bytes, so a push can never overwrite stored data. The transmit side is a one-cycle `tx_valid` strobe with no back-pressure, because a register write cannot be stalled.

Top module: `duart_regctl`

## Requirements
- R1: Register offset is `bus_addr[4:0]` XOR 1, and offset bit 4 selects the channel (0 = a, 1 = b). An access is decoded only when `bus_addr[7:5]` equals parameter `BLOCK_SEL` (default 0). Otherwise a read returns 0 and a write changes nothing.
- R2: After reset, both status registers read 0x00. `int_status`, `int_mask`, `rx_ready` and `tx_valid` are all 0.
- R3: Each channel has two mode entries at offset 0x01 (a) / 0x11 (b). A read or write uses the entry at the pointer and then sets the pointer to the second entry. After reset the pointer selects the first entry.
- R4: The command register sits at offset 0x05 / 0x15. Write bit 0 enables rx, bit 1 disables rx, bit 2 enables tx and bit 3 disables tx. If a write sets both bits of a pair, disable wins. Tx enabled shows as status bits 2 (tx ready) and 3 (tx empty) and as interrupt bit 0 (a) / 4 (b).
- R5: Command bits 7:4 are an opcode applied after the low bits. Opcode 1 returns the mode pointer to the first entry. Opcode 2 disables rx and empties the FIFO. Opcode 3 disables tx. Opcode 4 clears status bit 7. Opcode 5 clears both break interrupt bits. Every other opcode has no effect.
- R6: `rx_ready` is high only while rx is enabled and fewer than 3 bytes are stored. Whenever data is stored, status bit 0 and interrupt bit 1 (a) / 5 (b) are set. Status bit 1 is set while 3 bytes are stored.
- R7: A read of offset 0x07 / 0x17 returns the oldest byte and removes it. Removing the last byte clears status bit 0 and the rx interrupt bit. A read of an empty FIFO changes no status or interrupt bit.
- R8: An accepted push with `rx_brk` high stores 0x00. If status bit 7 was clear, the push also sets status bit 7 and interrupt bit 2 (a) / 6 (b). A holding read while status bit 7 is set clears bit 7 and sets the break interrupt bit. Opcode 5 written to either channel clears both break interrupt bits.
- R9: A write to offset 0x07 / 0x17 while tx is enabled raises `tx_valid` for that channel for one cycle after the write, with the byte on `tx_data`. While tx is disabled the byte is dropped.
- R10: Offset 0x0B reads the interrupt status in the layout given in R4, R6 and R8, with bits 3 and 7 always 0. A write to 0x0B loads `int_mask`. Reads of offsets that are not mapped return 0. Writes to 0x03, 0x13, 0x09 and 0x1B have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| rx_valid | input | 2 | Receive character valid, one bit per channel |
| rx_ready | output | 2 | Receive character accepted, one bit per channel |
| rx_data | input | 16 | Receive characters, channel a in bits 7:0 |
| rx_brk | input | 2 | Qualifies the pushed character as a break event |
| tx_valid | output | 2 | Transmit strobe, one bit per channel |
| tx_data | output | 16 | Transmit characters, channel a in bits 7:0 |
| int_status | output | 8 | Interrupt status bits for the aggregator |
| int_mask | output | 8 | Interrupt mask bits for the aggregator |

## Verification
The hardest situation to reach is the break bookkeeping. Its status flag and interrupt flag are cleared through different paths: a holding read, opcode 4, and opcode 5 written from the other channel. The stimulus stacks two break characters in channel b's FIFO. It clears the break interrupts through channel a, then pops the characters one at a time and checks that the first pop moves the sticky status into the interrupt bit and the second does not. A full-FIFO push attempt followed by a drain proves that the refused byte never reached storage.

// File: rtl/duart_pkg.sv
package duart_pkg;
  localparam int BYTE_W = 8;

  // register offset low nibble after the address XOR
  localparam logic [3:0] K_MODE = 4'h1;
  localparam logic [3:0] K_STAT = 4'h3;
  localparam logic [3:0] K_CMD  = 4'h5;
  localparam logic [3:0] K_HOLD = 4'h7;
  localparam logic [4:0] OFF_INT = 5'h0B;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_PTR_RST = 4'd1,
    OP_RX_RST  = 4'd2,
    OP_TX_RST  = 4'd3,
    OP_ERR_RST = 4'd4,
    OP_BRK_RST = 4'd5
  } cmd_op_e;
endpackage

// File: rtl/duart_rxfifo.sv
module duart_rxfifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [DW-1:0]            din,
  input  logic                     pop,
  input  logic                     flush,
  output logic [DW-1:0]            dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end
    end else begin
      if (push) begin
        mem[wp] <= din;
        wp      <= step(wp);
      end
      if (pop) rp <= step(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign count = cnt;

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < FULL));
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
endmodule

// File: rtl/duart_chan.sv
module duart_chan import duart_pkg::*; #(
  parameter int DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              mr_wr,
  input  logic              mr_rd,
  input  logic              cmd_wr,
  input  logic              thr_wr,
  input  logic              rhr_rd,
  input  logic              brkint_clr,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_brk,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] mr_q,
  output logic [BYTE_W-1:0] sr_q,
  output logic [BYTE_W-1:0] rhr_q,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic [2:0]        isr_q
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic              rx_en, tx_on, mr_ptr, brk_st, brk_int;
  logic [BYTE_W-1:0] mr [2];
  logic              rx_en_n, tx_on_n, brk_st_n, brk_int_n;
  logic              push, pop, flush;
  logic [CW-1:0]     cnt;
  logic [3:0]        op;

  assign op       = wdata[7:4];
  assign rx_ready = rx_en && (cnt != FULL);
  assign push     = rx_valid && rx_ready;
  assign pop      = rhr_rd && (cnt != '0);
  assign flush    = cmd_wr && (op == OP_RX_RST);

  duart_rxfifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (rx_brk ? '0 : rx_data),
    .pop   (pop),
    .flush (flush),
    .dout  (rhr_q),
    .count (cnt)
  );

  always_comb begin
    rx_en_n = rx_en;
    tx_on_n = tx_on;
    if (cmd_wr) begin
      if (wdata[0]) rx_en_n = 1'b1;
      if (wdata[1]) rx_en_n = 1'b0;
      if (wdata[2]) tx_on_n = 1'b1;
      if (wdata[3]) tx_on_n = 1'b0;
      if (op == OP_RX_RST) rx_en_n = 1'b0;
      if (op == OP_TX_RST) tx_on_n = 1'b0;
    end
  end

  always_comb begin
    brk_st_n  = brk_st;
    brk_int_n = brk_int;
    if (pop && brk_st) begin
      brk_st_n  = 1'b0;
      brk_int_n = 1'b1;
    end
    if (cmd_wr && (op == OP_ERR_RST)) brk_st_n = 1'b0;
    if (brkint_clr) brk_int_n = 1'b0;
    if (push && rx_brk && !brk_st_n) begin
      brk_st_n  = 1'b1;
      brk_int_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en    <= 1'b0;
      tx_on    <= 1'b0;
      mr_ptr   <= 1'b0;
      mr[0]    <= '0;
      mr[1]    <= '0;
      brk_st   <= 1'b0;
      brk_int  <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      rx_en    <= rx_en_n;
      tx_on    <= tx_on_n;
      brk_st   <= brk_st_n;
      brk_int  <= brk_int_n;
      if (mr_wr) mr[mr_ptr] <= wdata;
      if (cmd_wr && (op == OP_PTR_RST)) mr_ptr <= 1'b0;
      else if (mr_wr || mr_rd)           mr_ptr <= 1'b1;
      tx_valid <= thr_wr && tx_on;
      if (thr_wr && tx_on) tx_data <= wdata;
    end
  end

  assign mr_q  = mr[mr_ptr];
  assign sr_q  = {brk_st, 3'b000, tx_on, tx_on, (cnt == FULL), (cnt != '0)};
  assign isr_q = {brk_int, (cnt != '0), tx_on};

  // R3
  ptr_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_wr || mr_rd) |=> mr_ptr);
  // R9
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($past(thr_wr) && $past(tx_on)));
  // R5
  rx_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!sr_q[0] && !rx_ready));
  // R8
  brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && rx_brk && !brk_st) |=> (sr_q[7] && isr_q[2]));
endmodule

// File: rtl/duart_regctl.sv
module duart_regctl import duart_pkg::*; #(
  parameter logic [2:0] BLOCK_SEL = 3'd0,
  parameter int         DEPTH     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [7:0]   bus_wdata,
  output logic [7:0]   bus_rdata,
  input  logic [1:0]   rx_valid,
  output logic [1:0]   rx_ready,
  input  logic [15:0]  rx_data,
  input  logic [1:0]   rx_brk,
  output logic [1:0]   tx_valid,
  output logic [15:0]  tx_data,
  output logic [7:0]   int_status,
  output logic [7:0]   int_mask
);
  localparam int NCH = 2;

  logic       hit, wr_hit, rd_hit, brkint_clr;
  logic [4:0] off;
  logic [3:0] kind;
  logic       chsel;
  logic [NCH-1:0][BYTE_W-1:0] mr_q, sr_q, rhr_q;
  logic [NCH-1:0][2:0]        isr_q;

  assign hit    = (bus_addr[7:5] == BLOCK_SEL);
  assign off    = bus_addr[4:0] ^ 5'h01;
  assign kind   = off[3:0];
  assign chsel  = off[4];
  assign wr_hit = bus_wr && hit;
  assign rd_hit = bus_rd && !bus_wr && hit;
  assign brkint_clr = wr_hit && (kind == K_CMD) && (bus_wdata[7:4] == OP_BRK_RST);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel;
    assign sel = (chsel == 1'(g));
    duart_chan #(.DEPTH(DEPTH)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wdata      (bus_wdata),
      .mr_wr      (wr_hit && sel && (kind == K_MODE)),
      .mr_rd      (rd_hit && sel && (kind == K_MODE)),
      .cmd_wr     (wr_hit && sel && (kind == K_CMD)),
      .thr_wr     (wr_hit && sel && (kind == K_HOLD)),
      .rhr_rd     (rd_hit && sel && (kind == K_HOLD)),
      .brkint_clr (brkint_clr),
      .rx_valid   (rx_valid[g]),
      .rx_data    (rx_data[g*BYTE_W +: BYTE_W]),
      .rx_brk     (rx_brk[g]),
      .rx_ready   (rx_ready[g]),
      .mr_q       (mr_q[g]),
      .sr_q       (sr_q[g]),
      .rhr_q      (rhr_q[g]),
      .tx_valid   (tx_valid[g]),
      .tx_data    (tx_data[g*BYTE_W +: BYTE_W]),
      .isr_q      (isr_q[g])
    );
    assign int_status[4*g +: 4] = {1'b0, isr_q[g]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      int_mask <= '0;
    else if (wr_hit && off == OFF_INT) int_mask <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      case (kind)
        K_MODE:  bus_rdata = mr_q[chsel];
        K_STAT:  bus_rdata = sr_q[chsel];
        K_HOLD:  bus_rdata = rhr_q[chsel];
        default: bus_rdata = (off == OFF_INT) ? int_status : '0;
      endcase
    end
  end

  // R10
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && off == OFF_INT) |=> (int_mask == $past(bus_wdata)));
  // R1
  block_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit) |=> $stable(int_mask));
endmodule

// File: tb/duart_regctl_tb.sv
module duart_regctl_tb;
  localparam int CLK_NS = 4;
  localparam int NV = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [1:0]  rx_valid = '0, rx_ready, rx_brk = '0, tx_valid;
  logic [15:0] rx_data = '0, tx_data;
  logic [7:0]  int_status, int_mask;
  int          n_run = 0, n_fail = 0;
  logic [7:0]  rv;

  always #(CLK_NS/2) clk = ~clk;

  duart_regctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_brk(rx_brk), .tx_valid(tx_valid), .tx_data(tx_data),
    .int_status(int_status), .int_mask(int_mask)
  );

  // {is_read, addr, wdata_or_expected, requirement}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h02, 8'h00, 8'd2},  // R2 status a
    {1'b1, 8'h0A, 8'h00, 8'd2},  // R2 interrupt status
    {1'b0, 8'h00, 8'h13, 8'd3},  // R3 mode entry 1
    {1'b0, 8'h00, 8'h07, 8'd3},  // R3 mode entry 2
    {1'b0, 8'h00, 8'h55, 8'd3},  // R3 entry 2 again
    {1'b1, 8'h00, 8'h55, 8'd3},
    {1'b0, 8'h04, 8'h10, 8'd5},  // R5 pointer reset
    {1'b1, 8'h00, 8'h13, 8'd3},
    {1'b1, 8'h00, 8'h55, 8'd3},
    {1'b0, 8'h04, 8'h05, 8'd4},  // R4 rx+tx on a
    {1'b1, 8'h02, 8'h0C, 8'd4},
    {1'b1, 8'h0A, 8'h01, 8'd4},
    {1'b0, 8'h14, 8'h04, 8'd4},  // R4 tx on b
    {1'b1, 8'h0A, 8'h11, 8'd4},
    {1'b0, 8'h14, 8'h0C, 8'd4},  // R4 enable+disable: disable wins
    {1'b1, 8'h12, 8'h00, 8'd4},
    {1'b1, 8'h0A, 8'h01, 8'd4},
    {1'b0, 8'h04, 8'h34, 8'd5},  // R5 tx on + tx reset
    {1'b1, 8'h02, 8'h00, 8'd5},
    {1'b1, 8'h0A, 8'h00, 8'd5},
    {1'b0, 8'h04, 8'h04, 8'd4},
    {1'b0, 8'h04, 8'h60, 8'd5},  // R5 ignored opcode
    {1'b1, 8'h02, 8'h0C, 8'd5},
    {1'b0, 8'h0A, 8'h33, 8'd10}, // R10 mask write
    {1'b1, 8'h1A, 8'h00, 8'd10}, // R10 unmapped read
    {1'b0, 8'h02, 8'hFF, 8'd10}, // R10 clock-select write ignored
    {1'b1, 8'h02, 8'h0C, 8'd10},
    {1'b1, 8'h22, 8'h00, 8'd1},  // R1 other block reads 0
    {1'b0, 8'h24, 8'h08, 8'd1},  // R1 other block write ignored
    {1'b1, 8'h02, 8'h0C, 8'd1},
    {1'b0, 8'h14, 8'h01, 8'd4},  // rx on b
    {1'b1, 8'h12, 8'h00, 8'd4}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(input int ch, input logic [7:0] d, input logic brk);
    @(negedge clk);
    rx_valid[ch] = 1'b1; rx_brk[ch] = brk; rx_data[ch*8 +: 8] = d;
    @(negedge clk);
    rx_valid[ch] = 1'b0; rx_brk[ch] = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bus_read(a, d);
    check(tag, {8'h00, d}, {8'h00, exp});
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R2 reset rx_ready", {14'd0, rx_ready}, 16'h0000);
    check("R2 reset int_status", {8'h00, int_status}, 16'h0000);
    check("R2 reset int_mask", {8'h00, int_mask}, 16'h0000);
    check("R2 reset tx_valid", {14'd0, tx_valid}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        bus_read(VEC[i][23:16], rv);
        check($sformatf("R%0d vector %0d", VEC[i][7:0], i), {8'h00, rv}, {8'h00, VEC[i][15:8]});
      end else begin
        bus_write(VEC[i][23:16], VEC[i][15:8]);
      end
    end

    // R10 mask port
    check("R10 int_mask", {8'h00, int_mask}, 16'h0033);

    // R5 opcode after low bits: rx enable + rx reset leaves rx off
    bus_write(8'h04, 8'h21);
    check("R5 rx reset wins", {14'd0, rx_ready}, 16'h0002);
    bus_write(8'h04, 8'h01);
    check("R6 rx_ready on", {14'd0, rx_ready}, 16'h0003);

    // R6 fill channel a
    rx_push(0, 8'h41, 1'b0);
    rd_chk("R6 status one byte", 8'h02, 8'h0D);
    rd_chk("R6 rx interrupt", 8'h0A, 8'h03);
    rx_push(0, 8'h42, 1'b0);
    rx_push(0, 8'h43, 1'b0);
    check("R6 ready low when full", {14'd0, rx_ready}, 16'h0002);
    rd_chk("R6 status full", 8'h02, 8'h0F);
    rx_push(0, 8'h44, 1'b0);  // refused

    // R7 drain in order
    rd_chk("R7 pop 1", 8'h06, 8'h41);
    rd_chk("R7 status after pop", 8'h02, 8'h0D);
    rd_chk("R7 pop 2", 8'h06, 8'h42);
    rd_chk("R7 pop 3", 8'h06, 8'h43);
    rd_chk("R7 status empty", 8'h02, 8'h0C);
    rd_chk("R7 isr empty", 8'h0A, 8'h01);
    bus_read(8'h06, rv);      // empty read
    rd_chk("R7 empty read status", 8'h02, 8'h0C);
    rd_chk("R7 empty read isr", 8'h0A, 8'h01);
    rx_push(0, 8'h45, 1'b0);
    rd_chk("R6 refused byte not stored", 8'h06, 8'h45);

    // R8 break on channel b
    rx_push(1, 8'h99, 1'b1);
    rd_chk("R8 break status", 8'h12, 8'h81);
    rd_chk("R8 break isr", 8'h0A, 8'h61);
    rx_push(1, 8'h99, 1'b1);
    rd_chk("R8 second break status", 8'h12, 8'h81);
    bus_write(8'h04, 8'h50); // clear via channel a
    rd_chk("R8 cross-channel clear", 8'h0A, 8'h21);
    rd_chk("R8 zero char 1", 8'h16, 8'h00);
    rd_chk("R8 pop moves break to isr", 8'h0A, 8'h61);
    rd_chk("R8 status after pop", 8'h12, 8'h01);
    rd_chk("R8 zero char 2", 8'h16, 8'h00);
    rd_chk("R8 status drained", 8'h12, 8'h00);
    rd_chk("R8 isr drained", 8'h0A, 8'h41);
    bus_write(8'h14, 8'h50);
    rd_chk("R8 clear own", 8'h0A, 8'h01);
    rx_push(1, 8'h00, 1'b1);
    rd_chk("R8 break again", 8'h12, 8'h81);
    bus_write(8'h14, 8'h40);
    rd_chk("R5 error reset", 8'h12, 8'h01);
    rd_chk("R5 error reset keeps isr", 8'h0A, 8'h61);
    bus_write(8'h14, 8'h20);
    rd_chk("R5 rx reset status", 8'h12, 8'h00);
    check("R5 rx reset ready", {14'd0, rx_ready}, 16'h0001);
    rd_chk("R5 rx reset isr", 8'h0A, 8'h41);

    // R9 transmit
    bus_write(8'h06, 8'h5A);
    check("R9 tx strobe", {14'd0, tx_valid}, 16'h0001);
    check("R9 tx data", {8'h00, tx_data[7:0]}, 16'h005A);
    @(negedge clk);
    check("R9 tx one cycle", {14'd0, tx_valid}, 16'h0000);
    bus_write(8'h16, 8'h77);
    check("R9 tx dropped", {14'd0, tx_valid}, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule